// File: doc/BRIEF.md
# Byte Data Memory with Pointer Windows

This block is the data memory of a small 8-bit controller core. Its address space is 256 bytes. The upper part holds plain working RAM. The low part holds two pointer registers, two window addresses and a range of special function registers. Those registers live in neighbouring blocks and are reached through a forwarding port. Locations that are neither RAM nor a register read as zero and cannot be written.

The core reaches any location with a single request port. A request is one of four kinds: a byte read, a byte write, a single-bit set, or a single-bit clear. Reads return their data one cycle after the request. A bit operation reads, modifies and writes the location within its own cycle.

Address 00H and address 02H hold no storage of their own. Each acts as a window onto the location named by a pointer register: 00H uses the pointer at 01H, and 02H uses the pointer at 03H. An arithmetic or rotate operation is done by the core as two requests: a read, then a write of the result to the same address.

Top module: `dmem_ptrfile`

## Requirements
- R1: After reset, the pointer registers at 01H and 03H both read 00H, and `rd_valid` is low.
- R2: A write to an address in 40H..FFH stores the byte. A later read of that address returns it, with `rd_valid` high and `rd_data` holding the byte in the cycle after the read request.
- R3: A read or write at 00H acts on the location whose address is held in the pointer at 01H.
- R4: A read or write at 02H acts on the location whose address is held in the pointer at 03H.
- R5: If the pointer used by a window holds 00H or 02H, a read through that window returns 00H and a write through it changes nothing.
- R6: Addresses from SFR_LAST+1 (default 28H) up to 3FH read 00H. Writes and bit operations to them have no effect.
- R7: An access whose resolved address lies in 04H..SFR_LAST (default 27H) is forwarded. It raises `sfr_sel` in the request cycle, with `sfr_addr` set to the resolved address. A read returns `sfr_rdata` on `rd_data` one cycle later. This applies to direct accesses and to accesses through a window.
- R8: A bit-set request (`req_op`=2) sets bit `req_bit` of the target location and leaves its other bits unchanged.
- R9: A bit-clear request (`req_op`=3) clears bit `req_bit` of the target location and leaves its other bits unchanged.
- R10: A write or bit operation on a forwarded register raises `sfr_we` in the request cycle. For a bit operation, `sfr_wdata` is `sfr_rdata` with the one selected bit changed.
- R11: `rd_valid` is high only in the cycle after a read request (`req_op`=0). `sfr_we` is never high for a read (`req_op`=0) or when no request is present. Byte write is `req_op`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 bit set, 3 bit clear |
| req_addr | input | 8 | Requested address |
| req_wdata | input | 8 | Write data for byte writes |
| req_bit | input | 3 | Bit index for set and clear |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data, one cycle after the request |
| sfr_sel | output | 1 | Access targets a forwarded register |
| sfr_we | output | 1 | Write strobe to the forwarded register |
| sfr_addr | output | 8 | Resolved address of the forwarded register |
| sfr_wdata | output | 8 | Write data to the forwarded register |
| sfr_rdata | input | 8 | Read data from the forwarded register |

## Verification
The hardest case to reach is a window that points at a window, because it needs a chain of set-up writes. First a pointer must be loaded with 00H or 02H. Then both a read and a write are sent through the window that uses it, and the results are checked through the other pointer, which must be unchanged. A bit operation through a window into a forwarded register is also built step by step. The bench loads a pointer, seeds a register value through the bench's external register model, and then checks the modified byte on `sfr_wdata` within the request cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_BSET = 2'd2,
        OP_BCLR = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_PTR0 = 3'd1,
        TGT_PTR1 = 3'd2,
        TGT_SFR  = 3'd3,
        TGT_GPR  = 3'd4
    } tgt_e;

    // windows sit at even addresses 2*i, their pointers at 2*i+1
    localparam int NUM_WIN = 2;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SFR_FIRST = 4,
    parameter int SFR_LAST  = 39,
    parameter int GPR_BASE  = 64
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] ptrs,
    output tgt_e                           kind,
    output logic [ADDR_W-1:0]              eff_addr
);

    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN-1:0] eff_is_win;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            assign win_hit[gi]    = (addr == ADDR_W'(2 * gi));
            assign eff_is_win[gi] = (eff_addr == ADDR_W'(2 * gi));
        end
    endgenerate

    always_comb begin
        eff_addr = addr;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) eff_addr = ptrs[i];
        end
    end

    always_comb begin
        if (|eff_is_win) begin
            kind = TGT_NONE;
        end else if (eff_addr == ADDR_W'(1)) begin
            kind = TGT_PTR0;
        end else if (eff_addr == ADDR_W'(3)) begin
            kind = TGT_PTR1;
        end else if (eff_addr >= ADDR_W'(SFR_FIRST) && eff_addr <= ADDR_W'(SFR_LAST)) begin
            kind = TGT_SFR;
        end else if (eff_addr >= ADDR_W'(GPR_BASE)) begin
            kind = TGT_GPR;
        end else begin
            kind = TGT_NONE;
        end
    end

endmodule

// File: rtl/dmem_bitop.sv
module dmem_bitop
    import dmem_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] nxt
);

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = DATA_W'(1) << bit_idx;
        unique case (op)
            OP_WR:   nxt = wdata;
            OP_BSET: nxt = cur | mask;
            OP_BCLR: nxt = cur & ~mask;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dmem_gpr_bank.sv
module dmem_gpr_bank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int GPR_BASE = 64,
    localparam int DEPTH   = (1 << ADDR_W) - GPR_BASE,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  idx;

    assign off   = addr - ADDR_W'(GPR_BASE);
    assign idx   = off[IDX_W-1:0];
    assign rdata = mem_q[idx];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

endmodule

// File: rtl/dmem_ptrfile.sv
module dmem_ptrfile
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SFR_FIRST = 4,
    parameter int SFR_LAST  = 39,
    parameter int GPR_BASE  = 64,
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BIT_W-1:0]  req_bit,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_sel,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] mp0;
        logic [DATA_W-1:0] mp1;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } state_t;

    state_t state_d, state_q;

    op_e                           op;
    tgt_e                          kind;
    logic [ADDR_W-1:0]             eff_addr;
    logic [NUM_WIN-1:0][ADDR_W-1:0] ptrs;
    logic [DATA_W-1:0]             cur_val;
    logic [DATA_W-1:0]             new_val;
    logic [DATA_W-1:0]             gpr_rdata;
    logic                          is_read;
    logic                          wr_en;
    logic                          gpr_we;
    logic [DATA_W-1:0]             mp0_q;
    logic [DATA_W-1:0]             mp1_q;

    assign op      = op_e'(req_op);
    assign mp0_q   = state_q.mp0;
    assign mp1_q   = state_q.mp1;
    assign ptrs[0] = mp0_q[ADDR_W-1:0];
    assign ptrs[1] = mp1_q[ADDR_W-1:0];

    dmem_decode #(
        .ADDR_W   (ADDR_W),
        .SFR_FIRST(SFR_FIRST),
        .SFR_LAST (SFR_LAST),
        .GPR_BASE (GPR_BASE)
    ) u_decode (
        .addr    (req_addr),
        .ptrs    (ptrs),
        .kind    (kind),
        .eff_addr(eff_addr)
    );

    dmem_bitop #(
        .DATA_W(DATA_W)
    ) u_bitop (
        .op     (op),
        .cur    (cur_val),
        .wdata  (req_wdata),
        .bit_idx(req_bit),
        .nxt    (new_val)
    );

    dmem_gpr_bank #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .GPR_BASE(GPR_BASE)
    ) u_gpr (
        .clk  (clk),
        .we   (gpr_we),
        .addr (eff_addr),
        .wdata(new_val),
        .rdata(gpr_rdata)
    );

    always_comb begin
        is_read = req_valid && (op == OP_RD);
        wr_en   = req_valid && (op != OP_RD);

        unique case (kind)
            TGT_PTR0: cur_val = state_q.mp0;
            TGT_PTR1: cur_val = state_q.mp1;
            TGT_SFR:  cur_val = sfr_rdata;
            TGT_GPR:  cur_val = gpr_rdata;
            default:  cur_val = '0;
        endcase

        state_d          = state_q;
        state_d.rd_valid = is_read;
        if (is_read) state_d.rd_data = cur_val;
        if (wr_en && kind == TGT_PTR0) state_d.mp0 = new_val;
        if (wr_en && kind == TGT_PTR1) state_d.mp1 = new_val;

        gpr_we    = wr_en && (kind == TGT_GPR);
        sfr_sel   = req_valid && (kind == TGT_SFR);
        sfr_we    = wr_en && (kind == TGT_SFR);
        sfr_addr  = eff_addr;
        sfr_wdata = new_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid = state_q.rd_valid;
    assign rd_data  = state_q.rd_data;

endmodule

// File: rtl/dmem_ptrfile_chk.sv
module dmem_ptrfile_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SFR_FIRST = 4,
    parameter int SFR_LAST  = 39,
    parameter int GPR_BASE  = 64,
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BIT_W-1:0]  req_bit,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              sfr_sel,
    input logic              sfr_we,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] mp0,
    input logic [DATA_W-1:0] mp1
);

    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0) |=> rd_valid);

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == 2'd0) |=> !rd_valid);

    assert_sfr_we_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (req_valid && req_op != 2'd0));

    assert_sfr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> (sfr_addr >= ADDR_W'(SFR_FIRST) && sfr_addr <= ADDR_W'(SFR_LAST)));

    assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_addr > ADDR_W'(SFR_LAST)
         && req_addr < ADDR_W'(GPR_BASE)) |=> (rd_data == '0));

    assert_null_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_addr == '0
         && (mp0 == '0 || mp0 == DATA_W'(2))) |=> (rd_data == '0));

    assert_null_win1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_addr == ADDR_W'(2)
         && (mp1 == '0 || mp1 == DATA_W'(2))) |=> (rd_data == '0));

    assert_bset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && req_addr == ADDR_W'(1)) |=> mp0[$past(req_bit)]);

    assert_bclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && req_addr == ADDR_W'(3)) |=> !mp1[$past(req_bit)]);

endmodule

bind dmem_ptrfile dmem_ptrfile_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SFR_FIRST(SFR_FIRST),
    .SFR_LAST (SFR_LAST),
    .GPR_BASE (GPR_BASE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_bit  (req_bit),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .sfr_sel  (sfr_sel),
    .sfr_we   (sfr_we),
    .sfr_addr (sfr_addr),
    .mp0      (mp0_q),
    .mp1      (mp1_q)
);

// File: tb/dmem_ptrfile_tb_top.sv
module dmem_ptrfile_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [2:0] req_bit = 3'd0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       sfr_sel;
    logic       sfr_we;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    logic [7:0] sfr_mem [64];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sfr_rdata = sfr_mem[sfr_addr[5:0]];
    always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr[5:0]] <= sfr_wdata;

    dmem_ptrfile dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
        .rd_valid(rd_valid), .rd_data(rd_data), .sfr_sel(sfr_sel),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one request for one cycle; returns to idle at the next falling edge
    task automatic issue(input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] wd, input logic [2:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_bit = b;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        issue(2'd1, a, d, 3'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        issue(2'd0, a, 8'h00, 3'd0);
        chk({tag, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
        rd_chk("R1 ptr 01H", 8'h01, 8'h00);
        rd_chk("R1 ptr 03H", 8'h03, 8'h00);
    endtask

    task automatic t_gpr();
        wr(8'h40, 8'h11);
        chk("R11 no rd_valid after write", {7'd0, rd_valid}, 8'h00);
        wr(8'h7F, 8'hC3);
        wr(8'hFF, 8'h5A);
        rd_chk("R2 40H", 8'h40, 8'h11);
        rd_chk("R2 7FH", 8'h7F, 8'hC3);
        rd_chk("R2 FFH", 8'hFF, 8'h5A);
        @(negedge clk);
        chk("R11 idle rd_valid", {7'd0, rd_valid}, 8'h00);
    endtask

    task automatic t_win0();
        wr(8'h01, 8'h55);
        wr(8'h00, 8'hA5);
        rd_chk("R3 direct target", 8'h55, 8'hA5);
        wr(8'h55, 8'h3E);
        rd_chk("R3 window read", 8'h00, 8'h3E);
    endtask

    task automatic t_win1();
        wr(8'h03, 8'h80);
        wr(8'h02, 8'h3C);
        rd_chk("R4 direct target", 8'h80, 8'h3C);
        rd_chk("R4 window read", 8'h02, 8'h3C);
    endtask

    task automatic t_null();
        wr(8'h03, 8'h90);
        wr(8'h90, 8'h77);
        wr(8'h01, 8'h02);
        wr(8'h00, 8'h99);
        rd_chk("R5 window to 02H reads zero", 8'h00, 8'h00);
        rd_chk("R5 ptr0 kept", 8'h01, 8'h02);
        rd_chk("R5 ptr1 kept", 8'h03, 8'h90);
        rd_chk("R5 ptr1 target kept", 8'h90, 8'h77);
        wr(8'h03, 8'h00);
        wr(8'h02, 8'h44);
        rd_chk("R5 window to 00H reads zero", 8'h02, 8'h00);
        rd_chk("R5 ptr1 still zero", 8'h03, 8'h00);
    endtask

    task automatic t_resv();
        wr(8'h30, 8'hFF);
        rd_chk("R6 30H", 8'h30, 8'h00);
        issue(2'd2, 8'h3F, 8'h00, 3'd5);
        rd_chk("R6 3FH after bit set", 8'h3F, 8'h00);
        rd_chk("R6 28H", 8'h28, 8'h00);
    endtask

    task automatic t_sfr();
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 8'h10; req_wdata = 8'h6A;
        #1;
        chk("R7 sfr_sel on write", {7'd0, sfr_sel}, 8'h01);
        chk("R10 sfr_we on write", {7'd0, sfr_we}, 8'h01);
        chk("R7 sfr_addr", sfr_addr, 8'h10);
        chk("R10 sfr_wdata", sfr_wdata, 8'h6A);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
        rd_chk("R7 direct read", 8'h10, 8'h6A);
        wr(8'h01, 8'h12);
        sfr_mem[6'h12] = 8'hB7;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h00;
        #1;
        chk("R7 window sfr_addr", sfr_addr, 8'h12);
        chk("R11 no sfr_we on read", {7'd0, sfr_we}, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 window read", rd_data, 8'hB7);
    endtask

    task automatic t_bits();
        wr(8'h50, 8'h00);
        issue(2'd2, 8'h50, 8'h00, 3'd3);
        rd_chk("R8 set bit3", 8'h50, 8'h08);
        issue(2'd2, 8'h50, 8'h00, 3'd7);
        rd_chk("R8 set bit7", 8'h50, 8'h88);
        issue(2'd3, 8'h50, 8'h00, 3'd3);
        rd_chk("R9 clear bit3", 8'h50, 8'h80);
        wr(8'h03, 8'hFF);
        issue(2'd3, 8'h03, 8'h00, 3'd0);
        rd_chk("R9 clear ptr1 bit0", 8'h03, 8'hFE);
        wr(8'h01, 8'h50);
        issue(2'd2, 8'h00, 8'h00, 3'd0);
        rd_chk("R8 set through window", 8'h50, 8'h81);
    endtask

    task automatic t_sfr_bit();
        wr(8'h20, 8'hF0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 8'h20; req_bit = 3'd4;
        #1;
        chk("R10 bit clear sfr_we", {7'd0, sfr_we}, 8'h01);
        chk("R10 bit clear sfr_wdata", sfr_wdata, 8'hE0);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
        rd_chk("R10 sfr after clear", 8'h20, 8'hE0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpr();
        t_win0();
        t_win1();
        t_null();
        t_resv();
        t_sfr();
        t_bits();
        t_sfr_bit();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule